// File: doc/BRIEF.md
# Reset Pin Sequencer

This block sequences system reset around a single active-low, open-drain reset pin that is shared with external devices. It reads the pin through a synchronizer and pulls it low through a drive enable. Reset can come from power-on, from an internal request, or from an outside device pulling the pin low. Whatever the source, the block stretches the asserted pin for a fixed number of clock cycles and then lets go of the pin for a short settling window. At the end of that window it tests the pin level. If the pin is still low, it drives the pin low again and repeats the window and the test, until the pin reads high.

An external reset that arrives while the system is running is not taken at once. The sequencer first waits for the current bus cycle to end, or for a bus-monitor timeout, so that a write in flight can finish. While any reset is in progress the block asserts an internal module reset. On the last reset cycle it captures the boot configuration: a data word, a clock-source select bit and a breakpoint-mode bit. As reset ends it sends a one-cycle start pulse to the processor.

Top module: `rstpin_ctrl`

## Requirements
- R1: The pin level passes through a two-stage synchronizer before the sequencer uses it, and the sequencer acts only on clock edges. While running with `bus_end_i` high, a pin pulled low is first reflected as `mod_rst_o`=1 three clock edges after the low level is applied, and not at two edges.
- R2: While running, a low pin does not raise `mod_rst_o` until a cycle with `bus_end_i`=1 is seen. Without such a cycle, reset is entered after `BUSMON_CYC` cycles spent waiting.
- R3: After an external device releases the pin, the block drives the pin (`pin_drv_o`=1) for exactly `DRIVE_CYC` cycles.
- R4: An internal request (`int_req_i`=1) forces `pin_drv_o`=1 from the next cycle, from any state other than the wait for PLL lock, and this includes the release window. The drive counter stays cleared while the request is held, so a request lasting L cycles gives a drive of `DRIVE_CYC`+L-1 cycles.
- R5: Each drive period is followed by a window of exactly `SAMPLE_CYC` cycles in which `pin_drv_o`=0 and `mod_rst_o`=1.
- R6: At the end of the window, a high pin ends reset. A low pin starts another drive period of `DRIVE_CYC` cycles, followed by another window and test, and this repeats until the pin reads high.
- R7: While `por_i`=1 (asynchronous, active high), `pin_drv_o`=1, `mod_rst_o`=1, `cpu_start_o`=0 and all configuration outputs are 0. After `por_i` falls, the pin stays driven until `pll_lock_i`=1. From the lock, a further `DRIVE_CYC` drive cycles follow, then the window.
- R8: `mod_rst_o` stays high from reset entry until reset ends, and always for at least `MOD_MIN` cycles.
- R9: `boot_data_o`, `clk_sel_o` and `brk_mode_o` take the input values present on the last reset cycle. They then hold those values while the inputs change.
- R10: `cpu_start_o` is high for exactly one cycle per reset exit: the first cycle with `mod_rst_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_i | input | 1 | Power-on reset, asynchronous, active high |
| pll_lock_i | input | 1 | Clock synthesizer lock flag |
| int_req_i | input | 1 | Internal reset request |
| bus_end_i | input | 1 | Current bus cycle ends this cycle, or the bus is idle |
| pin_i | input | 1 | Level read back from the reset pin |
| pin_drv_o | output | 1 | Pull-low enable for the open-drain reset pin |
| mod_rst_o | output | 1 | Reset to the on-chip modules, active high |
| cpu_start_o | output | 1 | One-cycle pulse that starts the processor |
| boot_data_i | input | CFG_W | Data-bus level used for boot configuration |
| clk_sel_i | input | 1 | Clock-source select level |
| brk_mode_i | input | 1 | Breakpoint-mode select level |
| boot_data_o | output | CFG_W | Captured boot configuration word |
| clk_sel_o | output | 1 | Captured clock-source select |
| brk_mode_o | output | 1 | Captured breakpoint mode |

## Verification
The bench measures how long the drive and the release window last when the internal request is held for several different lengths. A counter that fails to stay cleared during the request would make these drives short. It also checks an external device that keeps the pin low through the first test. A sequencer that skipped the retest would then start the processor while the pin is still held. Two further tests check that a request arriving inside the release window restarts the drive, and that an external reset waits for the bus cycle boundary or for the timeout. A design without that deferral would raise the module reset in the middle of a write. Power-on checks the wait for PLL lock and the capture of the boot configuration, which must not follow the inputs once the processor has started.

// File: rtl/rstpin_pkg.sv
package rstpin_pkg;
   typedef enum logic [2:0] {
      ST_LOCK    = 3'd0,
      ST_DRIVE   = 3'd1,
      ST_RELEASE = 3'd2,
      ST_RUN     = 3'd3,
      ST_DEFER   = 3'd4,
      ST_HOLD    = 3'd5
   } rp_state_e;

   function automatic int max3(input int a, input int b, input int c);
      int m;
      m = (a > b) ? a : b;
      return (m > c) ? m : c;
   endfunction
endpackage

// File: rtl/rstpin_sync.sv
module rstpin_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic por_i,
   input  logic d_i,
   output logic q_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("rstpin_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] sh;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or posedge por_i)
            if (por_i) sh[0] <= 1'b0;
            else       sh[0] <= d_i;
      end else begin : g_next
         always_ff @(posedge clk or posedge por_i)
            if (por_i) sh[i] <= 1'b0;
            else       sh[i] <= sh[i-1];
      end
   end

   assign q_o = sh[STAGES-1];
endmodule

// File: rtl/rstpin_cfg.sv
module rstpin_cfg #(
   parameter int CFG_W = 16
) (
   input  logic             clk,
   input  logic             por_i,
   input  logic             load_i,
   input  logic [CFG_W-1:0] data_i,
   input  logic             sel_i,
   input  logic             brk_i,
   output logic [CFG_W-1:0] data_o,
   output logic             sel_o,
   output logic             brk_o
);
   localparam int TOT_W = CFG_W + 2;

   if (CFG_W < 1) begin : g_bad_w
      $error("rstpin_cfg: CFG_W must be positive");
   end

   logic [TOT_W-1:0] cfg_q;

   always_ff @(posedge clk or posedge por_i)
      if (por_i)       cfg_q <= '0;
      else if (load_i) cfg_q <= {data_i, sel_i, brk_i};

   assign data_o = cfg_q[TOT_W-1:2];
   assign sel_o  = cfg_q[1];
   assign brk_o  = cfg_q[0];

   // R9: captured configuration only moves on a load cycle
   a_r9_cfg_hold: assert property (@(posedge clk) disable iff (por_i)
      !load_i |=> $stable(cfg_q));
endmodule

// File: rtl/rstpin_seq.sv
module rstpin_seq
   import rstpin_pkg::*;
#(
   parameter int DRIVE_CYC  = 512,
   parameter int SAMPLE_CYC = 10,
   parameter int BUSMON_CYC = 64,
   parameter int MOD_MIN    = 4
) (
   input  logic clk,
   input  logic por_i,
   input  logic pll_lock_i,
   input  logic int_req_i,
   input  logic bus_end_i,
   input  logic pin_s_i,
   output logic pin_drv_o,
   output logic mod_rst_o,
   output logic cpu_start_o,
   output logic exit_o
);
   localparam int MAXC  = max3(DRIVE_CYC, SAMPLE_CYC, BUSMON_CYC);
   localparam int CNT_W = $clog2(MAXC + 1);
   localparam logic [CNT_W-1:0] DRV_LAST = CNT_W'(DRIVE_CYC - 1);
   localparam logic [CNT_W-1:0] SMP_LAST = CNT_W'(SAMPLE_CYC - 1);
   localparam logic [CNT_W-1:0] BM_LAST  = CNT_W'(BUSMON_CYC - 1);

   if (DRIVE_CYC < MOD_MIN) begin : g_bad_drive
      $error("rstpin_seq: DRIVE_CYC must cover MOD_MIN");
   end
   if (SAMPLE_CYC < 3) begin : g_bad_sample
      $error("rstpin_seq: SAMPLE_CYC must exceed the synchronizer delay");
   end
   if (BUSMON_CYC < 1) begin : g_bad_busmon
      $error("rstpin_seq: BUSMON_CYC must be positive");
   end

   rp_state_e        st, st_n;
   logic [CNT_W-1:0] cnt, cnt_n;
   logic             exit_c;

   always_comb begin
      st_n   = st;
      cnt_n  = cnt + 1'b1;
      exit_c = 1'b0;
      case (st)
         ST_LOCK: begin
            cnt_n = '0;
            if (pll_lock_i) st_n = ST_DRIVE;
         end
         ST_DRIVE: begin
            if (cnt == DRV_LAST) begin
               st_n  = ST_RELEASE;
               cnt_n = '0;
            end
         end
         ST_RELEASE: begin
            if (cnt == SMP_LAST) begin
               cnt_n = '0;
               if (pin_s_i) begin
                  st_n   = ST_RUN;
                  exit_c = 1'b1;
               end else begin
                  st_n = ST_DRIVE;
               end
            end
         end
         ST_RUN: begin
            cnt_n = '0;
            if (!pin_s_i) st_n = bus_end_i ? ST_HOLD : ST_DEFER;
         end
         ST_DEFER: begin
            if (bus_end_i || cnt == BM_LAST) begin
               st_n  = ST_HOLD;
               cnt_n = '0;
            end
         end
         ST_HOLD: begin
            cnt_n = '0;
            if (pin_s_i) st_n = ST_DRIVE;
         end
         default: begin
            st_n  = ST_LOCK;
            cnt_n = '0;
         end
      endcase
      if (int_req_i && st != ST_LOCK) begin
         st_n   = ST_DRIVE;
         cnt_n  = '0;
         exit_c = 1'b0;
      end
   end

   always_ff @(posedge clk or posedge por_i)
      if (por_i) begin
         st          <= ST_LOCK;
         cnt         <= '0;
         cpu_start_o <= 1'b0;
      end else begin
         st          <= st_n;
         cnt         <= cnt_n;
         cpu_start_o <= exit_c;
      end

   assign pin_drv_o = (st == ST_LOCK) || (st == ST_DRIVE);
   assign mod_rst_o = !((st == ST_RUN) || (st == ST_DEFER));
   assign exit_o    = exit_c;

   // run-length counters used by the checks below
   logic [CNT_W-1:0] chk_drv, chk_mrst;
   always_ff @(posedge clk or posedge por_i)
      if (por_i) begin
         chk_drv  <= '0;
         chk_mrst <= '0;
      end else begin
         chk_drv  <= !pin_drv_o ? '0 : (chk_drv == DRV_LAST) ? chk_drv : chk_drv + 1'b1;
         chk_mrst <= !mod_rst_o ? '0 : (chk_mrst == DRV_LAST) ? chk_mrst : chk_mrst + 1'b1;
      end

   // R4: a request pulls the pin low on the following cycle
   a_r4_req_drives: assert property (@(posedge clk) disable iff (por_i)
      int_req_i |=> pin_drv_o);
   // R3: a drive period never ends short
   a_r3_drive_len: assert property (@(posedge clk) disable iff (por_i)
      (pin_drv_o && st_n == ST_RELEASE) |-> chk_drv >= DRV_LAST);
   // R8: module reset never shorter than the minimum
   a_r8_modrst_min: assert property (@(posedge clk) disable iff (por_i)
      (mod_rst_o && st_n == ST_RUN) |-> chk_mrst >= CNT_W'(MOD_MIN - 1));
   // R10: start is a single pulse on the first running cycle
   a_r10_start_pulse: assert property (@(posedge clk) disable iff (por_i)
      cpu_start_o |=> !cpu_start_o);
   a_r10_start_exit: assert property (@(posedge clk) disable iff (por_i)
      cpu_start_o |-> (!mod_rst_o && $past(mod_rst_o)));
   // R5: the pin is never driven during the release window
   a_r5_window_free: assert property (@(posedge clk) disable iff (por_i)
      (st == ST_RELEASE && !int_req_i && cnt != SMP_LAST) |=> !pin_drv_o);
endmodule

// File: rtl/rstpin_ctrl.sv
module rstpin_ctrl #(
   parameter int DRIVE_CYC  = 512,
   parameter int SAMPLE_CYC = 10,
   parameter int BUSMON_CYC = 64,
   parameter int MOD_MIN    = 4,
   parameter int SYNC_STG   = 2,
   parameter int CFG_W      = 16
) (
   input  logic             clk,
   input  logic             por_i,
   input  logic             pll_lock_i,
   input  logic             int_req_i,
   input  logic             bus_end_i,
   input  logic             pin_i,
   output logic             pin_drv_o,
   output logic             mod_rst_o,
   output logic             cpu_start_o,
   input  logic [CFG_W-1:0] boot_data_i,
   input  logic             clk_sel_i,
   input  logic             brk_mode_i,
   output logic [CFG_W-1:0] boot_data_o,
   output logic             clk_sel_o,
   output logic             brk_mode_o
);
   logic pin_s;
   logic exit_w;

   rstpin_sync #(.STAGES(SYNC_STG)) u_sync (
      .clk   (clk),
      .por_i (por_i),
      .d_i   (pin_i),
      .q_o   (pin_s)
   );

   rstpin_seq #(
      .DRIVE_CYC  (DRIVE_CYC),
      .SAMPLE_CYC (SAMPLE_CYC),
      .BUSMON_CYC (BUSMON_CYC),
      .MOD_MIN    (MOD_MIN)
   ) u_seq (
      .clk         (clk),
      .por_i       (por_i),
      .pll_lock_i  (pll_lock_i),
      .int_req_i   (int_req_i),
      .bus_end_i   (bus_end_i),
      .pin_s_i     (pin_s),
      .pin_drv_o   (pin_drv_o),
      .mod_rst_o   (mod_rst_o),
      .cpu_start_o (cpu_start_o),
      .exit_o      (exit_w)
   );

   rstpin_cfg #(.CFG_W(CFG_W)) u_cfg (
      .clk    (clk),
      .por_i  (por_i),
      .load_i (exit_w),
      .data_i (boot_data_i),
      .sel_i  (clk_sel_i),
      .brk_i  (brk_mode_i),
      .data_o (boot_data_o),
      .sel_o  (clk_sel_o),
      .brk_o  (brk_mode_o)
   );
endmodule

// File: tb/sim_rstpin_ctrl.sv
module sim_rstpin_ctrl;
   localparam int CLK_P = 10;
   localparam int D  = 40;
   localparam int S  = 10;
   localparam int B  = 16;
   localparam int CW = 16;
   localparam int T  = 3*D + 3*S + 60;

   // kind, length, expected drive cycles, expected window cycles
   // kind 0: request of given length; 1: external hold through first test;
   // 2: second request inside the window; 3: external reset, bus end at t=8
   localparam int NV = 5;
   localparam int VEC [NV][4] = '{
      '{0, 1,  D,     S},
      '{0, 6,  D + 5, S},
      '{1, 0,  2*D,   2*S},
      '{2, 0,  2*D,   S + 3},
      '{3, 30, D,     S}
   };

   logic clk = 1'b0;
   logic por, lock, req, bend, ext_low;
   logic drv, mrst, start;
   logic [CW-1:0] bd_i, bd_o;
   logic cs_i, bm_i, cs_o, bm_o;
   logic pin;
   int n_chk = 0;
   int n_err = 0;

   always #(CLK_P/2) clk = ~clk;
   assign pin = !(drv || ext_low);

   rstpin_ctrl #(.DRIVE_CYC(D), .SAMPLE_CYC(S), .BUSMON_CYC(B), .CFG_W(CW)) u0 (
      .clk(clk), .por_i(por), .pll_lock_i(lock), .int_req_i(req),
      .bus_end_i(bend), .pin_i(pin), .pin_drv_o(drv), .mod_rst_o(mrst),
      .cpu_start_o(start), .boot_data_i(bd_i), .clk_sel_i(cs_i),
      .brk_mode_i(bm_i), .boot_data_o(bd_o), .clk_sel_o(cs_o), .brk_mode_o(bm_o)
   );

   task automatic chk(input string tag, input longint act, input longint exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic finish_seq();
      for (int i = 0; i < 2*D + 2*S + 20; i++) @(negedge clk);
   endtask

   task automatic run_vec(input int idx);
      int kind = VEC[idx][0];
      int len  = VEC[idx][1];
      int ndrv = 0, nrel = 0, nst = 0;
      logic seen = 1'b0;
      logic [CW-1:0] val = CW'(16'h1357 * (idx + 1));
      bd_i = val; cs_i = idx[0]; bm_i = !idx[0];
      for (int t = 0; t < T; t++) begin
         @(negedge clk);
         if (t > 0) begin
            if (drv) begin ndrv++; seen = 1'b1; end
            if (mrst && !drv && seen) nrel++;
            if (start) begin
               nst++;
               chk("R9 boot word at exit", bd_o, val);
               chk("R9 select bits at exit", {cs_o, bm_o}, {cs_i, bm_i});
               chk("R10 start with module reset low", mrst, 0);
            end
         end
         if (kind == 3 && t == 8) chk("R2 deferred until bus end", mrst, 0);
         if (kind == 3 && t == 9) chk("R2 entered at bus end", mrst, 1);
         case (kind)
            0: req = (t < len);
            1: begin req = (t == 0); ext_low = (t >= 1 && t < D + S + 5); end
            2: req = (t == 0 || t == D + 3);
            default: begin ext_low = (t >= 1 && t < 1 + len); bend = (t >= 8); end
         endcase
      end
      chk("R3/R4/R6 drive cycles", ndrv, VEC[idx][2]);
      chk("R5/R6 window cycles", nrel, VEC[idx][3]);
      chk("R10 one start per exit", nst, 1);
      req = 0; ext_low = 0; bend = 0;
   endtask

   initial begin
      #(CLK_P * 100000);
      n_err++; n_chk++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      int ndrv;
      por = 1; lock = 0; req = 0; bend = 0; ext_low = 0;
      bd_i = 16'hA5C3; cs_i = 1; bm_i = 0;
      repeat (3) @(negedge clk);
      chk("R7 pin driven in power-on", drv, 1);
      chk("R7 module reset in power-on", mrst, 1);
      chk("R7 no start in power-on", start, 0);
      chk("R7 config cleared", {bd_o, cs_o, bm_o}, 0);
      por = 0;
      repeat (20) @(negedge clk);
      chk("R7 pin held until lock", drv, 1);
      chk("R8 module reset before lock", mrst, 1);
      lock = 1;
      ndrv = 0;
      for (int t = 1; t <= D + S + 3; t++) begin
         @(negedge clk);
         if (drv) ndrv++;
         if (t == D + S) chk("R5 still in window", {mrst, drv}, 2'b10);
         if (t == D + S + 1) begin
            chk("R7 start after lock, drive and window", start, 1);
            chk("R9 boot word captured", bd_o, 16'hA5C3);
            chk("R9 select bits captured", {cs_o, bm_o}, 2'b10);
         end
      end
      chk("R7 drive cycles after lock", ndrv, D);
      bd_i = 16'h0F0F; cs_i = 0; bm_i = 1;
      repeat (3) @(negedge clk);
      chk("R9 config held after inputs change", {bd_o, cs_o, bm_o}, {16'hA5C3, 2'b10});
      chk("R10 start has ended", start, 0);

      for (int i = 0; i < NV; i++) run_vec(i);

      // R1: synchronizer delay with bus end always present
      bend = 1;
      @(negedge clk); ext_low = 1;
      repeat (2) @(negedge clk);
      chk("R1 not seen after two edges", mrst, 0);
      @(negedge clk);
      chk("R1 seen after three edges", mrst, 1);
      chk("R1 pin released while held outside", drv, 0);
      ext_low = 0; bend = 0;
      finish_seq();
      chk("R1 back to running", mrst, 0);

      // R2: bus-monitor timeout without a bus end
      @(negedge clk); ext_low = 1;
      repeat (B + 2) @(negedge clk);
      chk("R2 waiting for timeout", mrst, 0);
      @(negedge clk);
      chk("R2 timeout enters reset", mrst, 1);
      ext_low = 0;
      finish_seq();
      chk("R8 reset ended after timeout path", mrst, 0);

      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule